// File: doc/BRIEF.md
# Debounced Wake-Pin SMI Request Generator

This block watches three general-purpose wake pins and turns qualified level changes on them into system management interrupt (SMI) requests. Each raw pin first passes through a two-flop synchroniser. A debounce filter then accepts a new level only after the synchronised level has stayed there for a fixed 31 microsecond ticks. The filter works the same way on rising and falling changes.

A per-pin polarity bit sets which filtered level counts as active. When the filtered level moves into the active level, a sticky status bit is set. Software clears it by writing 1. A pin raises the SMI output only when all of these hold:

- its status bit is set,
- its SMI enable bit is set,
- it is configured as an input.

The same status can also go to a second routing path that is controlled by an external enable. The SMI enable takes priority over that path.

Software reaches the block through a byte-wide register port that selects one of two registers, and through a status port with a clear mask. A free-running one-microsecond tick paces the filters.

Top module: `wake_event_smi`

## Requirements
- R1: After reset, the polarity register, the control register and all status bits are 0, and `smi_req` and `alt_req` are low.
- R2: The polarity register is selected with `reg_sel`=0. Bit n sets the active level of pin n: 0 means active high, 1 means active low. Bits 7:3 always read 0, and writes to them have no effect.
- R3: The control register is selected with `reg_sel`=1. Bit n (n=0..2) is the direction of pin n, where 0 means input. Bit 4+n is the SMI enable of pin n, so bit 6 belongs to pin 2. Bits 7 and 3 always read 0.
- R4: After synchronisation, a new level is accepted only after it has held for 31 consecutive `us_tick` pulses. A level that returns before the 31st tick is discarded. Rising and falling changes are treated alike.
- R5: When a pin's filtered level changes into its active level (filtered level XOR polarity equal to 1), that pin's status bit is set on the same clock edge as the 31st tick. A filtered change into the inactive level sets nothing.
- R6: Writing a new polarity value never sets a status bit by itself.
- R7: Status bits are sticky. Writing 1 on `sts_clr_en`/`sts_clr_mask` clears the selected bits. If a clear and a new event for the same pin fall in the same cycle, the bit stays set.
- R8: `smi_req` is high exactly when some pin has its status set, its SMI enable set and its direction bit 0. It stays high until each such status bit is cleared.
- R9: `alt_req` is high when some pin has its status set, its `alt_route_en` bit set and its SMI enable clear. Setting the SMI enable removes that pin from `alt_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 polarity, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-1-to-clear mask, one bit per pin |
| sts_q | output | 3 | Sticky event status, one bit per pin |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| alt_route_en | input | 3 | Per-pin enable of the second routing path |
| wake_pin_raw | input | 3 | Asynchronous wake pins |
| smi_req | output | 1 | SMI request |
| alt_req | output | 1 | Request on the second routing path |

## Verification
Each filter is driven with pulses held for exactly 30 and exactly 31 ticks. This separates a correct threshold from one that is off by one. A 10-tick glitch shows that a short excursion is discarded.

The pins are tried with rising and falling changes under both polarity settings, which tells an edge-into-active event apart from a plain level or edge detector. A polarity write with no pin activity confirms that changing the polarity alone does not produce an event.

The clear-and-event collision checks which of the two wins. Sweeping the enable and direction bits against the external routing enables shows how the SMI gate and the override of the second path are wired.

// File: rtl/wake_pkg.sv
// Package: shared constants for the wake-pin SMI generator.
// Assumes three pins; the control register layout depends on that count.
package wake_pkg;
    localparam int unsigned NUM_WAKE   = 3;
    localparam int unsigned DB_TICKS   = 31;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned CTL_EN_LSB = 4;   // SMI enable field base bit
    localparam logic        SEL_POL    = 1'b0;
    localparam logic        SEL_CTL    = 1'b1;
endpackage

// File: rtl/wake_sync.sv
// Module: two-flop synchroniser for one asynchronous pin.
// Assumes the pin is quasi-static with respect to clk; reset value 0.
module wake_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Purpose: capture the pin in two back-to-back flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/wake_debounce.sv
// Module: tick-paced debounce filter.
// The filtered level follows the synchronised level only after TICKS
// consecutive ticks of disagreement; a return to the filtered level resets
// the count. upd_o pulses, combinationally, in the cycle the level flips.
module wake_debounce #(
    parameter int unsigned TICKS = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic lvl_i,
    output logic filt_o,
    output logic upd_o
);
    localparam int unsigned CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             differs;

    // Purpose: detect disagreement and the final qualifying tick.
    always_comb begin
        differs = (lvl_i != filt_o);
        upd_o   = differs && tick_i && (cnt_q == LAST);
    end

    // Purpose: count qualifying ticks and flip the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (!differs) begin
            cnt_q  <= '0;
        end else if (upd_o) begin
            cnt_q  <= '0;
            filt_o <= lvl_i;
        end else if (tick_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R4: the filtered level moves only on a tick that ends a full count.
    a_r4_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(tick_i) && $past(cnt_q) == LAST));
    // R4: the counter never passes the threshold.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/wake_regs.sv
// Module: polarity and control registers with read mux.
// Assumes NUM_WAKE <= 3 so both fields fit the byte layout.
module wake_regs
    import wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                sel,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic [NUM_WAKE-1:0] pol_o,
    output logic [NUM_WAKE-1:0] dir_o,
    output logic [NUM_WAKE-1:0] smien_o
);
    // Purpose: store only the implemented bits; reserved bits have no flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o   <= '0;
            dir_o   <= '0;
            smien_o <= '0;
        end else if (wr_en) begin
            if (sel == SEL_POL) begin
                pol_o <= wdata[NUM_WAKE-1:0];
            end else begin
                dir_o   <= wdata[NUM_WAKE-1:0];
                smien_o <= wdata[CTL_EN_LSB +: NUM_WAKE];
            end
        end
    end

    // Purpose: return the selected register, reserved bits as zero.
    always_comb begin
        rdata = '0;
        if (sel == SEL_POL) begin
            rdata[NUM_WAKE-1:0] = pol_o;
        end else begin
            rdata[NUM_WAKE-1:0]            = dir_o;
            rdata[CTL_EN_LSB +: NUM_WAKE]  = smien_o;
        end
    end

    // R2: reserved polarity bits read zero.
    a_r2_pol_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_POL) |-> (rdata[REG_W-1:NUM_WAKE] == '0));
    // R3: reserved control bits read zero.
    a_r3_ctl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTL) |-> (rdata[7] == 1'b0 && rdata[3] == 1'b0));
endmodule

// File: rtl/wake_event_smi.sv
// Module: top of the debounced wake-pin SMI generator.
// Per pin: synchroniser, debounce filter, polarity, sticky status.
// An event is a filtered transition into the active level, so polarity
// writes alone cannot raise status. Assumes us_tick is a 1-cycle pulse.
module wake_event_smi
    import wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                sts_clr_en,
    input  logic [NUM_WAKE-1:0] sts_clr_mask,
    output logic [NUM_WAKE-1:0] sts_q,
    input  logic                us_tick,
    input  logic [NUM_WAKE-1:0] alt_route_en,
    input  logic [NUM_WAKE-1:0] wake_pin_raw,
    output logic                smi_req,
    output logic                alt_req
);
    logic [NUM_WAKE-1:0] pol, dir, smien;
    logic [NUM_WAKE-1:0] lvl_sync, filt, upd, evt, clr;

    wake_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .pol_o   (pol),
        .dir_o   (dir),
        .smien_o (smien)
    );

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
        wake_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (wake_pin_raw[i]),
            .q_sync  (lvl_sync[i])
        );

        wake_debounce #(.TICKS(DB_TICKS)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (us_tick),
            .lvl_i  (lvl_sync[i]),
            .filt_o (filt[i]),
            .upd_o  (upd[i])
        );

        // Purpose: event when the new filtered level is the active one.
        always_comb evt[i] = upd[i] && (lvl_sync[i] ^ pol[i]);
    end

    // Purpose: form the write-1-to-clear mask.
    always_comb clr = sts_clr_en ? sts_clr_mask : '0;

    // Purpose: sticky status, a new event beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr) | evt;
    end

    // Purpose: SMI gate and the overridden second routing path.
    always_comb begin
        smi_req = |(sts_q & smien & ~dir);
        alt_req = |(sts_q & alt_route_en & ~smien);
    end

    // R7: a status bit only drops after a clear request for it.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|(sts_q & ~($past(clr)))) |-> 1'b0 || $past(sts_clr_en));
    // R6: status rises only from a filter update.
    a_r6_no_false_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[0]) |-> $past(upd[0]));
    // R8: SMI never asserts for a pin configured as an output only.
    a_r8_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (|(~dir & smien)));
endmodule

// File: tb/wake_event_smi_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module wake_event_smi_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sts_clr_en = 1'b0;
    logic [2:0] sts_clr_mask = '0;
    logic [2:0] sts_q;
    logic       us_tick = 1'b0;
    logic [2:0] alt_route_en = '0;
    logic [2:0] wake_pin_raw = '0;
    logic       smi_req, alt_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    wake_event_smi u_wake_event_smi (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask), .sts_q(sts_q),
        .us_tick(us_tick), .alt_route_en(alt_route_en),
        .wake_pin_raw(wake_pin_raw), .smi_req(smi_req), .alt_req(alt_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic pin(input int idx, input logic v);
        @(negedge clk); wake_pin_raw[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk); sts_clr_en = 1'b1; sts_clr_mask = m;
        @(negedge clk); sts_clr_en = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); check("R1 pol", d, 8'h00);
        rd(1'b1, d); check("R1 ctl", d, 8'h00);
        check("R1 sts", {5'b0, sts_q}, 8'h00);
        check("R1 smi", {6'b0, alt_req, smi_req}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(1'b0, 8'hFD); rd(1'b0, d); check("R2 pol rsvd", d, 8'h05);
        wr(1'b1, 8'hFF); rd(1'b1, d); check("R3 ctl rsvd", d, 8'h77);
        wr(1'b1, 8'h40); rd(1'b1, d); check("R3 bit6 pin2", d, 8'h40);
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_debounce();
        pin(0, 1'b1); ticks(10); pin(0, 1'b0); ticks(31);
        check("R4 glitch dropped", {5'b0, sts_q}, 8'h00);
        pin(0, 1'b1); ticks(30);
        check("R4 30 ticks", {5'b0, sts_q}, 8'h00);
        ticks(1);
        check("R4 R5 31 ticks rise", {5'b0, sts_q}, 8'h01);
        clr(3'b001);
        check("R7 clear", {5'b0, sts_q}, 8'h00);
        pin(0, 1'b0); ticks(31);
        check("R5 fall inactive", {5'b0, sts_q}, 8'h00);
    endtask

    task automatic t_polarity();
        wr(1'b0, 8'h02);
        repeat (3) @(negedge clk);
        check("R6 pol write no event", {5'b0, sts_q}, 8'h00);
        pin(1, 1'b1); ticks(31);
        check("R5 active-low rise none", {5'b0, sts_q}, 8'h00);
        wr(1'b0, 8'h00);
        check("R6 pol flip no event", {5'b0, sts_q}, 8'h00);
        wr(1'b0, 8'h02);
        pin(1, 1'b0); ticks(30);
        check("R4 fall 30 ticks", {5'b0, sts_q}, 8'h00);
        ticks(1);
        check("R5 active-low fall", {5'b0, sts_q}, 8'h02);
        clr(3'b010); wr(1'b0, 8'h00);
    endtask

    task automatic t_collide();
        pin(0, 1'b1); ticks(31);
        pin(0, 1'b0); ticks(31);
        check("R7 sticky held", {5'b0, sts_q}, 8'h01);
        pin(0, 1'b1); ticks(30);
        @(negedge clk); us_tick = 1'b1; sts_clr_en = 1'b1; sts_clr_mask = 3'b001;
        @(negedge clk); us_tick = 1'b0; sts_clr_en = 1'b0; sts_clr_mask = '0;
        check("R7 event wins", {5'b0, sts_q}, 8'h01);
        clr(3'b001);
        check("R7 cleared", {5'b0, sts_q}, 8'h00);
        pin(0, 1'b0); ticks(31);
    endtask

    task automatic t_smi();
        pin(2, 1'b1); ticks(31);
        check("R8 no enable", {7'b0, smi_req}, 8'h00);
        wr(1'b1, 8'h44);
        check("R8 output dir blocks", {7'b0, smi_req}, 8'h00);
        wr(1'b1, 8'h40);
        check("R8 smi asserted", {7'b0, smi_req}, 8'h01);
        alt_route_en = 3'b100; #1;
        check("R9 override", {7'b0, alt_req}, 8'h00);
        wr(1'b1, 8'h00);
        check("R9 alt path", {6'b0, alt_req, smi_req}, 8'h02);
        wr(1'b1, 8'h40);
        clr(3'b011);
        check("R8 other clear keeps", {7'b0, smi_req}, 8'h01);
        clr(3'b100);
        check("R8 cleared", {6'b0, alt_req, smi_req}, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_debounce();
        t_polarity();
        t_collide();
        t_smi();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule